// File: doc/BRIEF.md
# APB Requester with Chained and Spaced Transfers

This block turns commands from a valid/ready command port into APB transfers. Each command carries a direction bit, an address, write data and a spacing flag. An accepted command is driven as a setup cycle, with select high and enable low. An access cycle follows, with both select and enable high. For a read, the data on the read-data input is captured on the access cycle. It is returned one clock later on a single-cycle response strobe, together with the address of that read.

The spacing flag of the transfer in flight decides what may follow it. A chained transfer (flag = 1) accepts a new command during its own access cycle, so the next setup cycle follows with no gap. A spaced transfer (flag = 0) refuses commands during its access cycle, which forces at least one idle cycle before the next setup.

After a transfer, the address and direction lines keep their last values until the next setup cycle. They do not return to defaults. Wait states, error responses and multiple targets are not handled.

Top module: `apb_burst_requester`

## Requirements
- R1: While rstn is low, apb_sel, apb_en and cmd_ready are 0. A transfer in progress is dropped, and the address, direction and write-data lines return to 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. In the next cycle apb_sel=1 and apb_en=0 (setup), and apb_addr, apb_wr and apb_wdata carry that command's fields.
- R3: Every setup cycle is followed on the next clock by an access cycle (apb_sel=1, apb_en=1).
- R4: apb_en is high for exactly one clock per transfer.
- R5: apb_addr, apb_wr and apb_wdata do not change between the setup cycle and the access cycle of a transfer.
- R6: After an access cycle, apb_addr and apb_wr keep their values through idle cycles until the next setup cycle.
- R7: When the transfer in its access cycle has cmd_chain=1, cmd_ready is 1 in that cycle. A command accepted there starts its setup cycle on the next clock, so the two rising edges of apb_en are exactly 2 clocks apart.
- R8: When the transfer in its access cycle has cmd_chain=0, cmd_ready is 0 in that cycle and apb_sel is 0 in the next one. Rising edges of apb_en are therefore at least 3 clocks apart, with apb_en low for at least 2 clocks between them.
- R9: cmd_ready is 1 in every idle cycle (apb_sel=0) outside reset, and 0 in every setup cycle.
- R10: One clock after the access cycle of a read (apb_wr=0), rsp_valid is 1 for exactly one cycle. rsp_data holds the apb_rdata value present in that access cycle, and rsp_addr holds that read's address.
- R11: A write transfer produces no rsp_valid pulse.
- R12: While apb_sel is 1, apb_addr carries no X or Z bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstn | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | A command can be accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Target address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_chain | input | 1 | 1 = chained (next setup directly after access), 0 = spaced |
| apb_sel | output | 1 | Bus select |
| apb_en | output | 1 | Bus enable (access cycle) |
| apb_wr | output | 1 | Bus direction, 1 = write |
| apb_addr | output | ADDR_W | Bus address |
| apb_wdata | output | DATA_W | Bus write data |
| apb_rdata | input | DATA_W | Bus read data |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_data | output | DATA_W | Captured read data |
| rsp_addr | output | ADDR_W | Address of the returned read |

## Verification
In a chained stream, the access cycle of a read can coincide with the acceptance of the next command. The cycle after it then carries the read response and the new setup cycle together, while the address lines already show the new command. The bench provokes this by offering chained commands with no gap between them. The sequences covered are read-then-write, write-then-read and read-write-read to the same address. A behavioural model, compared on every clock, requires rsp_addr to name the completed read and not the address now on the bus.

// File: rtl/apb_req_pkg.sv
package apb_req_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } apb_phase_e;

  // A new command may be taken when the bus is idle, or during the access
  // cycle of a transfer that allows a chained successor.
  function automatic logic can_accept(apb_phase_e ph, logic chain);
    return (ph == PH_IDLE) || ((ph == PH_ACCESS) && chain);
  endfunction

  function automatic apb_phase_e phase_after(apb_phase_e ph, logic take);
    apb_phase_e nxt;
    case (ph)
      PH_IDLE:   nxt = take ? PH_SETUP : PH_IDLE;
      PH_SETUP:  nxt = PH_ACCESS;
      PH_ACCESS: nxt = take ? PH_SETUP : PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/apb_req_hold.sv
module apb_req_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstn,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn)     q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/apb_req_seq.sv
module apb_req_seq
  import apb_req_pkg::*;
(
  input  logic clk,
  input  logic rstn,
  input  logic cmd_valid,
  input  logic chain_cur,
  output logic cmd_ready,
  output logic accept,
  output logic sel,
  output logic en
);

  apb_phase_e phase_q;
  apb_phase_e phase_d;

  assign cmd_ready = rstn && can_accept(phase_q, chain_cur);
  assign accept    = cmd_valid && cmd_ready;
  assign phase_d   = phase_after(phase_q, accept);

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) phase_q <= PH_IDLE;
    else       phase_q <= phase_d;
  end

  assign sel = (phase_q != PH_IDLE);
  assign en  = (phase_q == PH_ACCESS);

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstn |-> (!sel && !en && !cmd_ready));

  p_setup_to_access_r3: assert property (@(posedge clk) disable iff (!rstn)
    (sel && !en) |=> (sel && en));

  p_access_single_r4: assert property (@(posedge clk) disable iff (!rstn)
    en |=> !en);

  p_chain_ready_r7: assert property (@(posedge clk) disable iff (!rstn)
    (en && chain_cur) |-> cmd_ready);

  p_spaced_blocked_r8: assert property (@(posedge clk) disable iff (!rstn)
    (en && !chain_cur) |-> !cmd_ready);

  p_spaced_gap_r8: assert property (@(posedge clk) disable iff (!rstn)
    (en && !chain_cur) |=> !sel);

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rstn)
    !sel |-> cmd_ready);

  p_setup_busy_r9: assert property (@(posedge clk) disable iff (!rstn)
    (sel && !en) |-> !cmd_ready);

endmodule

// File: rtl/apb_req_rsp.sv
module apb_req_rsp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              read_done,
  input  logic [DATA_W-1:0] rdata,
  input  logic [ADDR_W-1:0] addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rsp_addr
);

  always_ff @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= read_done;
      if (read_done) begin
        rsp_data <= rdata;
        rsp_addr <= addr;
      end
    end
  end

  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rstn)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/apb_burst_requester.sv
module apb_burst_requester #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstn,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_chain,
  output logic              apb_sel,
  output logic              apb_en,
  output logic              apb_wr,
  output logic [ADDR_W-1:0] apb_addr,
  output logic [DATA_W-1:0] apb_wdata,
  input  logic [DATA_W-1:0] apb_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] rsp_addr
);

  localparam int CMD_W = ADDR_W + DATA_W + 2;

  logic             accept;
  logic             chain_cur;
  logic             read_done;
  logic [CMD_W-1:0] cmd_vec;
  logic [CMD_W-1:0] held_vec;

  assign cmd_vec = {cmd_chain, cmd_write, cmd_addr, cmd_wdata};

  apb_req_hold #(.W(CMD_W)) u_hold (
    .clk  (clk),
    .rstn (rstn),
    .load (accept),
    .d    (cmd_vec),
    .q    (held_vec)
  );

  assign chain_cur = held_vec[CMD_W-1];
  assign apb_wr    = held_vec[CMD_W-2];
  assign apb_addr  = held_vec[DATA_W +: ADDR_W];
  assign apb_wdata = held_vec[DATA_W-1:0];

  apb_req_seq u_seq (
    .clk       (clk),
    .rstn      (rstn),
    .cmd_valid (cmd_valid),
    .chain_cur (chain_cur),
    .cmd_ready (cmd_ready),
    .accept    (accept),
    .sel       (apb_sel),
    .en        (apb_en)
  );

  assign read_done = apb_en && !apb_wr;

  apb_req_rsp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rstn      (rstn),
    .read_done (read_done),
    .rdata     (apb_rdata),
    .addr      (apb_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_addr  (rsp_addr)
  );

  p_accept_setup_r2: assert property (@(posedge clk) disable iff (!rstn)
    accept |=> (apb_sel && !apb_en && apb_addr == $past(cmd_addr)
                && apb_wr == $past(cmd_write) && apb_wdata == $past(cmd_wdata)));

  p_setup_fields_stable_r5: assert property (@(posedge clk) disable iff (!rstn)
    (apb_sel && !apb_en) |=> ($stable(apb_addr) && $stable(apb_wr) && $stable(apb_wdata)));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rstn)
    !apb_sel |-> ($stable(apb_addr) && $stable(apb_wr)));

  p_rsp_from_read_r10: assert property (@(posedge clk) disable iff (!rstn)
    rsp_valid |-> ($past(apb_en) && !$past(apb_wr) && rsp_data == $past(apb_rdata)
                   && rsp_addr == $past(apb_addr)));

  p_write_silent_r11: assert property (@(posedge clk) disable iff (!rstn)
    (apb_en && apb_wr) |=> !rsp_valid);

endmodule

// File: tb/apb_burst_requester_test.sv
module apb_burst_requester_test;

  logic        clk = 1'b0;
  logic        rstn = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic        cmd_chain = 1'b0;
  logic [31:0] apb_rdata = '0;
  logic        cmd_ready, apb_sel, apb_en, apb_wr, rsp_valid;
  logic [31:0] apb_addr, apb_wdata, rsp_data, rsp_addr;

  always #4 clk = ~clk;

  apb_burst_requester #(.ADDR_W(32), .DATA_W(32)) uut (
    .clk(clk), .rstn(rstn), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_chain(cmd_chain), .apb_sel(apb_sel), .apb_en(apb_en), .apb_wr(apb_wr),
    .apb_addr(apb_addr), .apb_wdata(apb_wdata), .apb_rdata(apb_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_addr(rsp_addr)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: 0 = bus idle, 1 = setup, 2 = access
  int          m_ph = 0;
  bit          m_chain, m_wr, m_rv, m_gap2;
  logic [31:0] m_addr, m_wdata, m_rdata, m_raddr;

  function automatic bit m_ready();
    return rstn && (m_ph == 0 || (m_ph == 2 && m_chain));
  endfunction

  always @(posedge clk or negedge rstn) begin
    if (!rstn) begin
      m_ph = 0; m_chain = 0; m_wr = 0; m_rv = 0; m_gap2 = 0;
      m_addr = '0; m_wdata = '0; m_rdata = '0; m_raddr = '0;
    end else begin
      bit take;
      take = cmd_valid && m_ready();
      m_rv = (m_ph == 2) && !m_wr;
      if (m_rv) begin
        m_rdata = apb_rdata;
        m_raddr = m_addr;
      end
      if (take) begin
        m_gap2  = (m_ph == 2);
        m_ph    = 1;
        m_chain = cmd_chain;
        m_wr    = cmd_write;
        m_addr  = cmd_addr;
        m_wdata = cmd_wdata;
      end else if (m_ph == 1) begin
        m_ph = 2;
      end else begin
        m_ph = 0;
      end
    end
  end

  // Per-cycle comparison away from the active edge
  int cyc = 0;
  int last_rise = -1;
  bit prev_en = 0;

  always @(negedge clk) begin
    cyc++;
    if (!rstn) begin
      chk(!apb_sel && !apb_en && !cmd_ready, "R1 quiet in reset",
          {29'd0, apb_sel, apb_en, cmd_ready}, 32'd0);
      chk(apb_addr === 32'd0 && apb_wdata === 32'd0, "R1 fields cleared", apb_addr, 32'd0);
      last_rise = -1;
      prev_en = 0;
    end else begin
      chk(apb_sel === (m_ph != 0), "R3 select", {31'd0, apb_sel}, {31'd0, m_ph != 0});
      chk(apb_en === (m_ph == 2), "R4 enable", {31'd0, apb_en}, {31'd0, m_ph == 2});
      chk(cmd_ready === m_ready(),
          (m_ph == 2) ? (m_chain ? "R7 ready in chained access" : "R8 ready in spaced access")
                      : "R9 ready", {31'd0, cmd_ready}, {31'd0, m_ready()});
      chk(apb_addr === m_addr, (m_ph == 1) ? "R2 address" : (m_ph == 2) ? "R5 address" : "R6 address",
          apb_addr, m_addr);
      chk(apb_wr === m_wr, (m_ph == 0) ? "R6 direction" : "R2 direction",
          {31'd0, apb_wr}, {31'd0, m_wr});
      if (m_ph != 0)
        chk(apb_wdata === m_wdata, (m_ph == 1) ? "R2 write data" : "R5 write data",
            apb_wdata, m_wdata);
      chk(rsp_valid === m_rv, m_rv ? "R10 response strobe" : "R11 no response",
          {31'd0, rsp_valid}, {31'd0, m_rv});
      if (m_rv) begin
        chk(rsp_data === m_rdata, "R10 response data", rsp_data, m_rdata);
        chk(rsp_addr === m_raddr, "R10 response address", rsp_addr, m_raddr);
      end
      if (apb_sel)
        chk((^apb_addr) !== 1'bx, "R12 defined address", apb_addr, m_addr);
      if (apb_en && !prev_en) begin
        if (last_rise >= 0) begin
          if (m_gap2)
            chk(cyc - last_rise == 2, "R7 enable spacing", cyc - last_rise, 2);
          else
            chk(cyc - last_rise >= 3, "R8 enable spacing", cyc - last_rise, 3);
        end
        last_rise = cyc;
      end
      prev_en = apb_en;
    end
  end

  // Read data changes every cycle so a wrong capture cycle is visible
  logic [31:0] rd_seed = 32'h1357_9bdf;
  always @(negedge clk) begin
    #1;
    rd_seed   = rd_seed + 32'h0101_0013;
    apb_rdata = rd_seed ^ 32'hC0DE_0000;
  end

  // Called at a falling edge + 1 ns
  task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d,
                       input bit ch, input int gap);
    for (int g = 0; g < gap; g++) begin
      cmd_valid = 0;
      @(negedge clk); #1;
    end
    cmd_valid = 1; cmd_write = wr; cmd_addr = a; cmd_wdata = d; cmd_chain = ch;
    while (!cmd_ready) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    cmd_valid = 0;
  endtask

  task automatic idle(input int n);
    cmd_valid = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #2 rstn = 0;
    repeat (3) @(negedge clk);
    #1 rstn = 1;
    idle(2);
    // R8: spaced write then spaced read of the same address
    issue(1, 32'h0000_0040, 32'hDEAD_0001, 0, 0);
    issue(0, 32'h0000_0040, 32'h0, 0, 0);
    idle(3);
    // R7: chained write then read, same address
    issue(1, 32'h0000_0080, 32'h1111_2222, 1, 0);
    issue(0, 32'h0000_0080, 32'h0, 1, 0);
    idle(3);
    // R7: chained write, write, read to one address
    issue(1, 32'h0000_00C0, 32'hAAAA_0001, 1, 0);
    issue(1, 32'h0000_00C0, 32'hAAAA_0002, 1, 0);
    issue(0, 32'h0000_00C0, 32'h0, 1, 0);
    idle(3);
    // R10/R7: chained read, write, read; response overlaps next setup
    issue(0, 32'h0000_0100, 32'h0, 1, 0);
    issue(1, 32'h0000_0100, 32'h5555_6666, 1, 0);
    issue(0, 32'h0000_0100, 32'h0, 1, 0);
    idle(2);
    // R8: spaced reads offered with no gap
    issue(0, 32'h0000_0200, 32'h0, 0, 0);
    issue(0, 32'h0000_0204, 32'h0, 0, 0);
    issue(0, 32'h0000_0208, 32'h0, 0, 0);
    idle(4);
    // Mixed stream of modes, directions and gaps
    for (int i = 0; i < 48; i++)
      issue(i % 3 != 0, 32'h0000_1000 + 32'((i % 7) * 4), 32'h7000_0000 + 32'(i * 977),
            ((i / 2) % 2) == 1, (i % 5 == 4) ? 2 : 0);
    idle(3);
    // R1: reset during a setup cycle drops the transfer
    cmd_valid = 1; cmd_write = 0; cmd_addr = 32'h0000_3000; cmd_chain = 1;
    @(negedge clk); #1;
    cmd_valid = 0;
    rstn = 0;
    idle(3);
    rstn = 1;
    idle(2);
    issue(0, 32'h0000_3004, 32'h0, 0, 0);
    idle(5);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule